// File: doc/BRIEF.md
# Label-Filtered Receive Interrupt Controller

This block raises interrupts for eight serial receive channels. Each received word arrives as a channel number, an 8-bit label and a valid strobe, at most one per clock. A bit table holds one enable bit for every channel and label pair, 8 x 256 bits in all. A word whose bit is set is treated as interrupt-worthy. It sets its channel's bit in a pending register, and its label is written into that channel's own capture register.

A host writes the enable table one bit at a time and writes an 8-bit channel mask. It reads the pending register through a read strobe. The read returns the current value and clears the register at the end of that cycle. The host can also read any channel's captured label.

The interrupt output is a level. It rises after a qualifying word on a channel whose mask bit is set. It stays high until the acknowledge input is seen high. The output first holds a minimum pulse of PULSE_CYC cycles, 1 us at the default clock, and acknowledge is ignored during that pulse. If acknowledge is tied high, the output therefore gives a single pulse of fixed width.

Top module: `label_irq_ctrl`

## Requirements
- R1: A receive event sets pending bit `rx_chan` one cycle later only when the table bit for that channel and `rx_label` is 1. Pending bit i belongs to channel i.
- R2: A qualifying event writes `rx_label` into the capture register of its channel. A non-qualifying event leaves every capture register unchanged.
- R3: Pending bits from different channels accumulate until a host read.
- R4: While `pend_rd` is high, `pend_rdata` shows the current pending value. The register reads 0x00 after that clock edge.
- R5: A qualifying event in the same cycle as a clearing read leaves its own pending bit set after the read.
- R6: `irq` rises one cycle after a qualifying event on a channel whose mask bit is 1. A qualifying event on a channel whose mask bit is 0 does not raise `irq`.
- R7: Once high, `irq` stays high until `ack` is sampled high after the minimum pulse. It falls one cycle after that sample.
- R8: With `ack` held high, `irq` is high for exactly PULSE_CYC cycles, which is CLK_MHZ cycles (1 us).
- R9: Reset clears the pending register, every capture register, `irq`, the enable table and the mask.
- R10: A table write (`tbl_we`, with `tbl_bit` as the new value) and a mask write (`mask_we`) take effect for events from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive event strobe |
| rx_chan | input | 3 | Channel of the received word |
| rx_label | input | 8 | Label of the received word |
| tbl_we | input | 1 | Enable table bit write |
| tbl_chan | input | 3 | Table write channel |
| tbl_label | input | 8 | Table write label |
| tbl_bit | input | 1 | Table write value |
| mask_we | input | 1 | Mask register write |
| mask_wdata | input | 8 | New mask, bit i gates channel i |
| pend_rd | input | 1 | Host read of the pending register, clears it |
| pend_rdata | output | 8 | Pending register value |
| cap_sel | input | 3 | Capture register select |
| cap_rdata | output | 8 | Captured label of the selected channel |
| ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Level interrupt output |

## Verification
Pending bits, captured labels and the rise of `irq` are all due one clock after the event, so the bench samples them 1 ns after the next rising edge. The read value is sampled before the edge that ends the read, and the cleared value 1 ns after that edge. A rise in `ack` shows up on `irq` one edge after it is sampled. The held-acknowledge pulse is measured by counting `irq` high samples taken one per cycle, starting at the edge that captured the event.

// File: rtl/label_irq_ctrl.sv
module label_irq_ctrl #(
  parameter int NUM_CH  = 8,
  parameter int LABEL_W = 8,
  parameter int CLK_MHZ = 100
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_valid,
  input  logic [$clog2(NUM_CH)-1:0] rx_chan,
  input  logic [LABEL_W-1:0]        rx_label,
  input  logic                      tbl_we,
  input  logic [$clog2(NUM_CH)-1:0] tbl_chan,
  input  logic [LABEL_W-1:0]        tbl_label,
  input  logic                      tbl_bit,
  input  logic                      mask_we,
  input  logic [NUM_CH-1:0]         mask_wdata,
  input  logic                      pend_rd,
  output logic [NUM_CH-1:0]         pend_rdata,
  input  logic [$clog2(NUM_CH)-1:0] cap_sel,
  output logic [LABEL_W-1:0]        cap_rdata,
  input  logic                      ack,
  output logic                      irq
);
  localparam int NLBL      = 1 << LABEL_W;
  localparam int PULSE_CYC = CLK_MHZ;
  localparam int CNT_W     = $clog2(PULSE_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_WAIT} irq_st_t;

  logic [NUM_CH-1:0][NLBL-1:0]    en_tbl;
  logic [NUM_CH-1:0][LABEL_W-1:0] cap;
  logic [NUM_CH-1:0]              pend, mask, set_vec;
  logic [CNT_W-1:0]               cnt;
  irq_st_t                        st;
  logic                           hit, trig;

  assign hit     = rx_valid && en_tbl[rx_chan][rx_label];
  assign set_vec = hit ? (NUM_CH'(1) << rx_chan) : '0;
  assign trig    = hit && mask[rx_chan];

  assign pend_rdata = pend;
  assign cap_rdata  = cap[cap_sel];
  assign irq        = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_tbl <= '0;
      mask   <= '0;
    end else begin
      if (tbl_we) en_tbl[tbl_chan][tbl_label] <= tbl_bit;
      if (mask_we) mask <= mask_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      cap  <= '0;
    end else begin
      pend <= (pend_rd ? '0 : pend) | set_vec;
      if (hit) cap[rx_chan] <= rx_label;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        S_IDLE:
          if (trig) begin
            st  <= S_PULSE;
            cnt <= CNT_W'(PULSE_CYC - 1);
          end
        S_PULSE:
          if (cnt == '0) st <= ack ? S_IDLE : S_WAIT;
          else           cnt <= cnt - 1'b1;
        S_WAIT:
          if (ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module label_irq_chk #(
  parameter int NUM_CH  = 8,
  parameter int CLK_MHZ = 100
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      rx_valid,
  input logic [$clog2(NUM_CH)-1:0] rx_chan,
  input logic                      pend_rd,
  input logic [NUM_CH-1:0]         pend_rdata,
  input logic                      hit,
  input logic                      trig,
  input logic                      ack,
  input logic                      irq
);
  a_r1_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend_rdata[$past(rx_chan)]);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !pend_rd) |=> $stable(pend_rdata));
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_rd && !rx_valid) |=> (pend_rdata == '0));
  a_r6_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !irq) |=> irq);
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !trig) |=> !irq);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);
  a_r8_min: assert property (@(posedge clk) disable iff (!rst_n)
    (CLK_MHZ > 1 && $rose(irq)) |=> irq);
endmodule

bind label_irq_ctrl label_irq_chk #(.NUM_CH(NUM_CH), .CLK_MHZ(CLK_MHZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_chan(rx_chan),
  .pend_rd(pend_rd), .pend_rdata(pend_rdata), .hit(hit), .trig(trig),
  .ack(ack), .irq(irq)
);

// File: tb/tb_label_irq_ctrl.sv
module tb_label_irq_ctrl;
  logic       clk = 0, rst_n = 0;
  logic       rx_valid = 0, tbl_we = 0, tbl_bit = 0, mask_we = 0, pend_rd = 0, ack = 0;
  logic [2:0] rx_chan = 0, tbl_chan = 0, cap_sel = 0;
  logic [7:0] rx_label = 0, tbl_label = 0, mask_wdata = 0;
  logic [7:0] pend_rdata, cap_rdata;
  logic       irq;
  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_cap [8];

  label_irq_ctrl dut (.*);

  always #5 clk = ~clk;

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tbl_wr(input int ch, input int lbl, input bit v);
    tbl_we = 1; tbl_chan = 3'(ch); tbl_label = 8'(lbl); tbl_bit = v;
    tick(); tbl_we = 0;
  endtask

  task automatic ev(input int ch, input int lbl);
    rx_valid = 1; rx_chan = 3'(ch); rx_label = 8'(lbl);
    tick(); rx_valid = 0;
  endtask

  task automatic caps(input string req);
    for (int c = 0; c < 8; c++) begin
      cap_sel = 3'(c); #1;
      chk(req, cap_rdata, exp_cap[c]);
    end
  endtask

  localparam logic [11:0] VEC [8] = '{
    {1'b1, 3'd7, 8'hD4}, {1'b1, 3'd0, 8'h00}, {1'b1, 3'd3, 8'hFF}, {1'b0, 3'd3, 8'hFE},
    {1'b1, 3'd5, 8'h31}, {1'b0, 3'd6, 8'hD4}, {1'b1, 3'd2, 8'h80}, {1'b0, 3'd2, 8'h7F}
  };

  initial begin
    for (int c = 0; c < 8; c++) exp_cap[c] = 0;
    tick(); tick(); rst_n = 1; tick();
    chk("R9 pend", pend_rdata, 0);
    chk("R9 irq", irq, 0);
    caps("R9 cap");

    tbl_wr(7, 'hD4, 1); tbl_wr(0, 'h00, 1); tbl_wr(3, 'hFF, 1);
    tbl_wr(5, 'h31, 1); tbl_wr(2, 'h80, 1);

    for (int i = 0; i < 8; i++) begin
      automatic int h = VEC[i][11], ch = VEC[i][10:8], lb = VEC[i][7:0];
      ev(ch, lb);
      if (h) exp_cap[ch] = 8'(lb);
      chk("R1 pend", pend_rdata, h ? (1 << ch) : 0);
      chk("R6 masked", irq, 0);
      caps("R2 cap");
      pend_rd = 1; #1;
      chk("R4 read", pend_rdata, h ? (1 << ch) : 0);
      tick(); pend_rd = 0;
      chk("R4 cleared", pend_rdata, 0);
    end

    ev(7, 'hD4); ev(3, 'hFF);
    chk("R3 accumulate", pend_rdata, 8'h88);
    pend_rd = 1; rx_valid = 1; rx_chan = 0; rx_label = 0;
    tick(); pend_rd = 0; rx_valid = 0;
    chk("R5 survive", pend_rdata, 8'h01);
    pend_rd = 1; tick(); pend_rd = 0;

    mask_we = 1; mask_wdata = 8'h80; tick(); mask_we = 0;
    ev(3, 'hFF);
    chk("R6 masked-out", irq, 0);
    ev(7, 'hD4);
    chk("R6 rise", irq, 1);
    for (int k = 0; k < 150; k++) tick();
    chk("R7 held", irq, 1);
    ack = 1; tick();
    chk("R7 fall", irq, 0);
    ev(7, 'hD4);
    begin
      int hi = 0;
      while (irq && hi < 1000) begin hi++; tick(); end
      chk("R8 pulse", hi, 100);
    end
    ack = 0;

    tbl_wr(7, 'hD4, 0);
    pend_rd = 1; tick(); pend_rd = 0;
    ev(7, 'hD4);
    chk("R10 tbl off", pend_rdata, 0);
    chk("R10 irq off", irq, 0);
    mask_we = 1; mask_wdata = 8'h08; tick(); mask_we = 0;
    ev(3, 'hFF);
    chk("R10 mask on", irq, 1);

    rst_n = 0; tick(); rst_n = 1;
    for (int c = 0; c < 8; c++) exp_cap[c] = 0;
    chk("R9 pend2", pend_rdata, 0);
    chk("R9 irq2", irq, 0);
    caps("R9 cap2");
    ev(3, 'hFF);
    chk("R9 tbl cleared", pend_rdata, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule